// File: doc/BRIEF.md
# Serial Flash Continuous-Read Master

This block is the master side of a four-wire SPI link in mode 0 that pulls a run of bytes out of a serial flash with a single continuous array read. The user side gives a one-cycle start request together with the transfer settings, all sampled on that cycle:
- a speed selector, which picks one of two read opcodes;
- a page-layout selector, which picks either a page-number plus byte-offset address or a flat byte address;
- the address fields;
- a byte count;
- a clock divider setting.

The block holds chip select low for the whole transfer. While it does, it sends the opcode, three address bytes and, for the fast read only, one dummy byte. It then keeps clocking and returns each received byte with a one-cycle valid strobe. When the last byte is in, it raises chip select and pulses done.

The serial clock comes from the system clock. Every half period of the serial clock lasts `div_i + 1` system cycles.

The sequencer has five states:
- `ST_IDLE`: waits for a start request.
- `ST_LOW`: the serial clock is low.
- `ST_HIGH`: the serial clock is high.
- `ST_TRAIL`: the final low half period, with chip select still low.
- `ST_DONE`: one cycle with chip select high and done asserted.

The transitions are:
- IDLE to LOW on a start with a nonzero count.
- IDLE to DONE on a start with a zero count.
- LOW to HIGH on a phase tick.
- HIGH to LOW on a phase tick when more bits remain.
- HIGH to TRAIL on a phase tick after the final data bit.
- TRAIL to DONE on a phase tick.
- DONE to IDLE unconditionally.

Top module: `flash_stream_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, busy_o is 0, done_o is 0 and data_valid_o is 0.
- R2: With fast_i=1 the master sends 40 bits, most significant bit first, before the first data bit: opcode 0x0B, the 24-bit address, then a dummy byte 0x00.
- R3: With fast_i=0 the master sends 32 bits, most significant bit first: opcode 0x03 and then the 24-bit address. The next rising edge of the serial clock samples the first data bit.
- R4: With page264_i=1 the 24-bit address is {3'b000, page_i[11:0], offset_i[8:0]}. The page number sits in address bits 20..9 and the byte offset in bits 8..0.
- R5: With page264_i=0 the 24-bit address is {4'b0000, flat_addr_i[19:0]}.
- R6: The serial clock idles low. Every half period, including the lead-in from chip-select fall to the first rising edge, lasts exactly div_i+1 system cycles. mosi_o does not change while sclk_o stays high. miso_i is sampled in the cycle in which sclk_o rises.
- R7: cs_n_o falls once per transfer and stays low from the first opcode bit to the last data bit. It rises only after one further low half period following the last falling edge of the serial clock.
- R8: Exactly count_i bytes are delivered. Each byte is assembled most significant bit first and appears on data_o with a one-cycle data_valid_o pulse, in the cycle after the rising edge that samples its eighth bit.
- R9: busy_o equals the inverse of cs_n_o. done_o is a single-cycle pulse in the first cycle in which cs_n_o is high again.
- R10: A start with count_i=0 gives a done_o pulse in the next cycle. cs_n_o never falls and busy_o stays 0.
- R11: While a transfer runs, start_i and every setting input are ignored. The transfer finishes with its original header, count and divider, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request; settings are captured with it |
| fast_i | input | 1 | 1: opcode 0x0B with dummy byte; 0: opcode 0x03 |
| page264_i | input | 1 | 1: page/offset address; 0: flat address |
| div_i | input | DIV_W | Half period of the serial clock minus one, in system cycles |
| page_i | input | 12 | Page number (page/offset mode) |
| offset_i | input | 9 | Byte offset within the page (page/offset mode) |
| flat_addr_i | input | 20 | Byte address (flat mode) |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| data_o | output | 8 | Received byte |
| data_valid_o | output | 1 | data_o holds a new byte |

## Verification
The bench acts as a flash slave. It captures every bit the master sends on a rising serial-clock edge and drives miso on falling edges. It checks, on every cycle, the half-period lengths, the rule that MOSI stays still while the clock is high, and that busy and chip select agree.

The read is tried with four combinations of speed and page layout, using different dividers and byte counts:
- fast with page/offset;
- slow with page/offset;
- fast with flat addressing;
- slow with flat addressing.

Comparing the fast and slow runs shows whether the dummy byte is present and where data sampling starts. Comparing the page/offset and flat runs shows the two address packings apart. An offset of 0x1FF and a page of 0xABC expose any misplaced bit at the 9-bit field boundary.

A zero count shows the early-completion path. A second start with changed settings, issued in the middle of a transfer, shows whether the captured settings are held.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int PAGE_BITS = 12;
    localparam int OFS_BITS  = 9;
    localparam int FLAT_BITS = 20;
    localparam int ADDR_BITS = 24;
    localparam int HDR_BITS  = 8 + ADDR_BITS + 8;
    localparam int LEN_W     = $clog2(HDR_BITS + 1);
    localparam logic [7:0] OP_FAST = 8'h0B;
    localparam logic [7:0] OP_SLOW = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_DONE
    } rd_state_e;
endpackage

// File: rtl/fr_hdr.sv
module fr_hdr
    import fr_pkg::*;
(
    input  logic                 fast_i,
    input  logic                 page264_i,
    input  logic [PAGE_BITS-1:0] page_i,
    input  logic [OFS_BITS-1:0]  offset_i,
    input  logic [FLAT_BITS-1:0] flat_i,
    output logic [HDR_BITS-1:0]  word_o,
    output logic [LEN_W-1:0]     len_o
);
    localparam int PAD_PAGED = ADDR_BITS - PAGE_BITS - OFS_BITS;
    localparam int PAD_FLAT  = ADDR_BITS - FLAT_BITS;

    logic [ADDR_BITS-1:0] addr;

    always_comb begin
        if (page264_i) begin
            addr = {{PAD_PAGED{1'b0}}, page_i, offset_i};
        end else begin
            addr = {{PAD_FLAT{1'b0}}, flat_i};
        end
        word_o = {(fast_i ? OP_FAST : OP_SLOW), addr, 8'h00};
        len_o  = fast_i ? LEN_W'(HDR_BITS) : LEN_W'(HDR_BITS - 8);
    end
endmodule

// File: rtl/fr_tick.sv
module fr_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the phase counter never passes the captured half-period limit
    p_tick_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/fr_rxbyte.sv
module fr_rxbyte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_i,
    input  logic       bit_i,
    input  logic       last_i,
    output logic [7:0] data_o,
    output logic       valid_o
);
    logic [7:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= shift_i && last_i;
            if (shift_i) begin
                sr_q <= {sr_q[6:0], bit_i};
                if (last_i) begin
                    data_o <= {sr_q[6:0], bit_i};
                end
            end
        end
    end

    // R8: a byte strobe never lasts more than one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/flash_stream_reader.sv
module flash_stream_reader
    import fr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 fast_i,
    input  logic                 page264_i,
    input  logic [DIV_W-1:0]     div_i,
    input  logic [PAGE_BITS-1:0] page_i,
    input  logic [OFS_BITS-1:0]  offset_i,
    input  logic [FLAT_BITS-1:0] flat_addr_i,
    input  logic [CNT_W-1:0]     count_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 mosi_o,
    input  logic                 miso_i,
    output logic [7:0]           data_o,
    output logic                 data_valid_o
);
    rd_state_e            state_q, state_d;
    logic                 tick;
    logic                 running;
    logic                 launch;
    logic                 last_bit;
    logic                 sample_en;
    logic [DIV_W-1:0]     div_q;
    logic [HDR_BITS-1:0]  hdr_word;
    logic [HDR_BITS-1:0]  hdr_sr;
    logic [LEN_W-1:0]     hdr_len;
    logic [LEN_W-1:0]     hdr_left;
    logic [2:0]           bitpos;
    logic [CNT_W-1:0]     bytes_left;

    assign running   = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TRAIL);
    assign launch    = (state_q == ST_IDLE) && start_i && (count_i != '0);
    assign last_bit  = (hdr_left == '0) && (bitpos == 3'd7) && (bytes_left == CNT_W'(1));
    assign sample_en = (state_q == ST_LOW) && tick && (hdr_left == '0);

    fr_hdr u_hdr (
        .fast_i    (fast_i),
        .page264_i (page264_i),
        .page_i    (page_i),
        .offset_i  (offset_i),
        .flat_i    (flat_addr_i),
        .word_o    (hdr_word),
        .len_o     (hdr_len)
    );

    fr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .div_i  (div_q),
        .tick_o (tick)
    );

    fr_rxbyte u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sample_en),
        .bit_i   (miso_i),
        .last_i  (bitpos == 3'd7),
        .data_o  (data_o),
        .valid_o (data_valid_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (count_i == '0) ? ST_DONE : ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) state_d = last_bit ? ST_TRAIL : ST_LOW;
            end
            ST_TRAIL: begin
                if (tick) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n_o = !running;
        busy_o = running;
        sclk_o = (state_q == ST_HIGH);
        done_o = (state_q == ST_DONE);
        mosi_o = running && hdr_sr[HDR_BITS-1];
    end

    // bit-stream datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_sr     <= '0;
            hdr_left   <= '0;
            bitpos     <= '0;
            bytes_left <= '0;
            div_q      <= '0;
        end else if (launch) begin
            hdr_sr     <= hdr_word;
            hdr_left   <= hdr_len;
            bitpos     <= '0;
            bytes_left <= count_i;
            div_q      <= div_i;
        end else if ((state_q == ST_HIGH) && tick) begin
            hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
            if (hdr_left != '0) begin
                hdr_left <= hdr_left - 1'b1;
            end else begin
                bitpos <= bitpos + 1'b1;
                if (bitpos == 3'd7) begin
                    bytes_left <= bytes_left - 1'b1;
                end
            end
        end
    end

    // R6: data towards the flash only moves on a falling clock edge
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R7: chip select only returns high into the completion cycle
    p_cs_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cs_n_o) && cs_n_o) |-> done_o);

    // R8: received bytes appear only during the data phase of a transfer
    p_valid_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (!cs_n_o && (hdr_left == '0)));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: an empty request completes at once with chip select high
    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start_i && (count_i == '0)) |=> (done_o && cs_n_o));
endmodule

// File: tb/tb_flash_stream_reader.sv
module tb_flash_stream_reader;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, fast_i = 1'b0, page264_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic [11:0] page_i = '0;
    logic [8:0] offset_i = '0;
    logic [19:0] flat_addr_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic busy_o, done_o, cs_n_o, sclk_o, mosi_o;
    logic miso_i = 1'b0;
    logic [7:0] data_o;
    logic data_valid_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_stream_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
        .page264_i(page264_i), .div_i(div_i), .page_i(page_i),
        .offset_i(offset_i), .flat_addr_i(flat_addr_i), .count_i(count_i),
        .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .data_o(data_o),
        .data_valid_o(data_valid_o)
    );

    int total = 0;
    int bad = 0;

    // expectations for the transfer in flight
    int exp_hdr_len = 32;
    int exp_div = 0;
    int exp_cnt = 0;
    int exp_seed = 0;

    // slave/monitor state
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    logic [39:0] hdr_got = '0;
    int nbits = 0, ph = 0, viol_t = 0, viol_d = 0, rcv = 0;
    int cs_falls = 0, busy_viol = 0;

    function automatic logic [7:0] pat(int seed, int j);
        int v;
        v = seed * 29 + j * 73 + 5;
        return v[7:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // behavioural flash slave and per-cycle protocol checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o != !cs_n_o) busy_viol++;
            if (cs_n_o && sclk_o) viol_t++;
            if (prev_cs && !cs_n_o) begin
                cs_falls++;
                hdr_got = '0;
                nbits = 0;
                ph = 1;
                viol_t = 0;
                viol_d = 0;
                rcv = 0;
                miso_i = 1'b0;
            end else if (!cs_n_o || !prev_cs) begin
                if (sclk_o != prev_sclk || cs_n_o != prev_cs) begin
                    if (ph != exp_div + 1) viol_t++;
                    ph = 1;
                end else begin
                    ph++;
                end
                if (!cs_n_o && prev_sclk && sclk_o && mosi_o != prev_mosi) viol_t++;
                if (sclk_o && !prev_sclk) begin
                    nbits++;
                    if (nbits <= exp_hdr_len) hdr_got = {hdr_got[38:0], mosi_o};
                end
                if (!sclk_o && prev_sclk && !cs_n_o && nbits >= exp_hdr_len) begin
                    int k;
                    logic [7:0] b;
                    k = nbits - exp_hdr_len;
                    b = pat(exp_seed, k / 8);
                    miso_i = (k / 8 < exp_cnt) ? b[7 - (k % 8)] : 1'b0;
                end
                if (cs_n_o) miso_i = 1'b0;
            end
            if (data_valid_o) begin
                if (data_o != pat(exp_seed, rcv)) viol_d++;
                rcv++;
            end
            prev_cs = cs_n_o;
            prev_sclk = sclk_o;
            prev_mosi = mosi_o;
        end
    end

    task automatic run(bit fast, bit p264, logic [11:0] pg, logic [8:0] ofs,
                       logic [19:0] flat, int cnt, int dv, int seed, bit mid_start);
        logic [23:0] addr;
        logic [39:0] exp_hdr;
        int falls0, bv0, guard;
        string rq_hdr, rq_addr;
        addr = p264 ? {3'b000, pg, ofs} : {4'b0000, flat};
        exp_hdr = fast ? {8'h0B, addr, 8'h00} : {8'h00, 8'h03, addr};
        exp_hdr_len = fast ? 40 : 32;
        exp_div = dv;
        exp_cnt = cnt;
        exp_seed = seed;
        rq_hdr = fast ? "R2" : "R3";
        rq_addr = p264 ? "R4" : "R5";
        falls0 = cs_falls;
        bv0 = busy_viol;
        @(negedge clk);
        fast_i = fast; page264_i = p264; page_i = pg; offset_i = ofs;
        flat_addr_i = flat; count_i = CNT_W'(cnt); div_i = DIV_W'(dv);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!done_o && guard < 20000) begin
            guard++;
            if (mid_start && guard == 60) begin
                // R11: new settings and a start request while busy
                fast_i = !fast; page264_i = !p264; page_i = ~pg; offset_i = ~ofs;
                flat_addr_i = ~flat; count_i = CNT_W'(cnt + 3); div_i = DIV_W'(dv + 2);
                start_i = 1'b1;
            end
            if (mid_start && guard == 61) start_i = 1'b0;
            @(negedge clk);
        end
        check(done_o == 1'b1, "R9", "done reached", done_o, 1);
        if (fast) check(hdr_got == exp_hdr, rq_hdr, "fast header", hdr_got, exp_hdr);
        else check(hdr_got[31:0] == exp_hdr[31:0], rq_hdr, "slow header", hdr_got[31:0], exp_hdr[31:0]);
        check(((fast ? hdr_got[31:8] : hdr_got[23:0]) == addr), rq_addr, "address packing",
              fast ? hdr_got[31:8] : hdr_got[23:0], addr);
        check(viol_t == 0, "R6", "clock phase/mosi violations", viol_t, 0);
        check(cs_falls - falls0 == 1, "R7", "chip-select falls", cs_falls - falls0, 1);
        check(rcv == cnt, "R8", "bytes delivered", rcv, cnt);
        check(viol_d == 0, "R8", "byte value mismatches", viol_d, 0);
        check(cs_n_o == 1'b1 && busy_o == 1'b0, "R9", "cs high, busy low at done", {cs_n_o, busy_o}, 2'b10);
        @(negedge clk);
        check(done_o == 1'b0, "R9", "done width", done_o, 0);
        check(busy_viol == bv0, "R9", "busy vs chip select", busy_viol - bv0, 0);
        if (mid_start) begin
            repeat (20) @(negedge clk);
            check(cs_falls - falls0 == 1 && cs_n_o, "R11", "no second transfer", cs_falls - falls0, 1);
            fast_i = fast; page264_i = p264;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(cs_n_o == 1'b1 && sclk_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0 && data_valid_o == 1'b0,
              "R1", "reset outputs", {cs_n_o, sclk_o, busy_o, done_o, data_valid_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n_o == 1'b1 && busy_o == 1'b0, "R1", "idle after reset", {cs_n_o, busy_o}, 2'b10);

        run(1'b1, 1'b1, 12'hABC, 9'h107, 20'h0, 3, 1, 1, 1'b0);
        run(1'b0, 1'b1, 12'h001, 9'h1FF, 20'h0, 2, 0, 2, 1'b0);
        run(1'b1, 1'b0, 12'h0, 9'h0, 20'hFEDCB, 2, 2, 3, 1'b0);
        run(1'b0, 1'b0, 12'h0, 9'h0, 20'h12345, 1, 3, 4, 1'b0);

        // R10: zero-length request
        begin
            int falls0;
            int busy_seen;
            falls0 = cs_falls;
            busy_seen = 0;
            count_i = '0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(done_o == 1'b1, "R10", "immediate done", done_o, 1);
            if (busy_o) busy_seen++;
            repeat (5) begin
                @(negedge clk);
                if (busy_o) busy_seen++;
            end
            check(cs_falls == falls0 && busy_seen == 0, "R10", "no chip select, no busy",
                  cs_falls - falls0 + busy_seen, 0);
        end

        run(1'b1, 1'b1, 12'h5A5, 9'h0F0, 20'h0, 4, 1, 5, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule